// File: doc/BRIEF.md
# Fixed-Width Truncated Multiplier with Selectable Error Compensation

This block multiplies an `NA`-bit operand by an `NB`-bit operand and returns only the `RW` most significant bits of the product, rounded. One unit in the last place of the result (ulp) is worth `2^(NA+NB-RW)` in product units. Only the top `RW+KG` columns of the partial-product matrix are built. The `KG` extra columns are guard columns that are discarded after summation. The `T = NA+NB-RW-KG` lowest columns are never formed.

The value that is lost from the omitted columns is replaced by a correction word. Three compensation styles are available. The constant style adds a precomputed word. The variable style also feeds the partial-product bits of column `T-1` up into column `T`, so the correction follows the operands. The hybrid style feeds up only a percentage of those bits. In every style the constant is derived at elaboration time from the expected value of each omitted bit, taking every operand bit as equally likely to be 0 or 1. The constant also includes a half-ulp rounding offset, less half a guard LSB.

A parameter selects two's-complement operands. In that case the sign-row and sign-column partial products are inverted and the matching bias is merged into the constant. A second parameter places a register on the result.

Top module: `tmul_trunc`

## Requirements
- R1: With unsigned operands, `prod_out` is the unsigned `RW`-bit approximation of `a_in*b_in / 2^(NA+NB-RW)`. For example, with 6x6 operands and `RW=6`, 63*63 gives 62 or 63.
- R2: In constant mode (`MODE=CORR_CONST`), `|prod_out*ulp - a_in*b_in| <= ulp` holds for every operand pair.
- R3: In variable mode (`MODE=CORR_VAR`), every bit of column `T-1` is fed into column `T`, and the same one-ulp bound holds for every operand pair.
- R4: In hybrid mode (`MODE=CORR_HYBRID`), `floor(H*HYB_PCT/100)` bits of column `T-1` are fed up, where `H` is the height of that column, and the one-ulp bound holds for every operand pair.
- R5: With `SGN=1`, the operands and `prod_out` are two's complement, and the one-ulp bound holds against the signed exact product.
- R6: Over all operand pairs of a mode, the mean error is at most a quarter ulp in magnitude.
- R7: When either operand is zero, `prod_out` is zero.
- R8: With `REG_OUT=1`, `prod_out` is cleared by a synchronous active-high `rst`. It shows the result of the operands sampled at the previous rising edge, so it changes one cycle after the inputs change.
- R9: With `REG_OUT=0`, `prod_out` follows the operands in the same cycle, and `clk` and `rst` have no effect on it.
- R10: While both operands hold steady, `prod_out` holds steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | NA | Multiplicand |
| b_in | input | NB | Multiplier |
| prod_out | output | RW | Rounded fixed-width product |

## Verification
The bench builds four copies with 6-bit operands, a 6-bit result and three guard columns, which leaves three omitted columns. The copies cover the constant, variable and 50 % hybrid styles unsigned and registered, plus hybrid with signed operands and a combinational output. At these widths every one of the 4096 operand pairs can be swept in each style. The worst-case error is checked on every pair and the mean error over the whole sweep. The combinational copy and the registered copies run side by side, which makes the one-cycle latency and the reset behaviour directly observable.

// File: rtl/tmul_pkg.sv
package tmul_pkg;

    typedef enum logic [1:0] {
        CORR_CONST  = 2'd0,
        CORR_VAR    = 2'd1,
        CORR_HYBRID = 2'd2
    } corr_mode_e;

    // lowest multiplicand index present in column c
    function automatic int col_lo(input int c, input int nb);
        return (c - nb + 1 > 0) ? c - nb + 1 : 0;
    endfunction

    // highest multiplicand index present in column c
    function automatic int col_hi(input int c, input int na);
        return (c < na - 1) ? c : na - 1;
    endfunction

    function automatic int col_height(input int c, input int na, input int nb);
        int h;
        h = col_hi(c, na) - col_lo(c, nb) + 1;
        return (h > 0) ? h : 0;
    endfunction

    // signed operands: bits pairing exactly one sign bit are inverted
    function automatic bit is_inv(input int i, input int j, input int na,
                                  input int nb, input bit sgn);
        return sgn && ((i == na - 1) != (j == nb - 1));
    endfunction

    function automatic int fed_count(input corr_mode_e mode, input int na,
                                     input int nb, input int t, input int pct);
        int h;
        h = col_height(t - 1, na, nb);
        case (mode)
            CORR_VAR:    return h;
            CORR_HYBRID: return (h * pct) / 100;
            default:     return 0;
        endcase
    endfunction

    // Correction word in product units, already aligned to column t.
    // Works in quarter units: an AND bit averages 1/4, an inverted one 3/4.
    function automatic longint corr_word(input int na, input int nb, input int rw,
                                         input int kg, input corr_mode_e mode,
                                         input int pct, input bit sgn);
        int     w;
        int     t;
        int     nv;
        int     lo;
        longint x4;
        w  = na + nb;
        t  = w - rw - kg;
        nv = fed_count(mode, na, nb, t, pct);
        x4 = 0;
        for (int c = 0; c < t; c++)
            for (int i = col_lo(c, nb); i <= col_hi(c, na); i++)
                x4 += (is_inv(i, c - i, na, nb, sgn) ? 3 : 1) * (longint'(1) << c);
        if (sgn)
            x4 += 4 * ((longint'(1) << (na - 1)) + (longint'(1) << (nb - 1))
                       + (longint'(1) << (w - 1)));
        x4 += longint'(1) << (w - rw + 1);
        x4 -= longint'(1) << (t + 1);
        lo = col_lo(t - 1, nb);
        for (int k = 0; k < nv; k++)
            x4 -= (is_inv(lo + k, t - 1 - lo - k, na, nb, sgn) ? 3 : 1)
                  * (longint'(1) << t);
        return ((x4 + (longint'(1) << (t + 1))) >>> (t + 2)) <<< t;
    endfunction

endpackage

// File: rtl/tmul_ppmat.sv
module tmul_ppmat #(
    parameter int NA   = 8,
    parameter int NB   = 8,
    parameter int T    = 5,
    parameter int NV   = 2,
    parameter bit SGN  = 1'b0,
    localparam int W    = NA + NB,
    localparam int NV_W = (NV > 0) ? NV : 1
) (
    input  logic [NA-1:0]         a,
    input  logic [NB-1:0]         b,
    output logic [NB-1:0][W-1:0]  rows,
    output logic [NV_W-1:0]       fed_bits
);
    localparam int FED_LO = tmul_pkg::col_lo(T - 1, NB);

    // kept partial products, one row per multiplier bit
    for (genvar j = 0; j < NB; j++) begin : g_row
        for (genvar c = 0; c < W; c++) begin : g_col
            localparam int I = c - j;
            if (c >= T && I >= 0 && I < NA) begin : g_keep
                localparam bit INV = tmul_pkg::is_inv(I, j, NA, NB, SGN);
                assign rows[j][c] = (a[I] & b[j]) ^ INV;
            end else begin : g_zero
                assign rows[j][c] = 1'b0;
            end
        end
    end

    // bits of the first omitted column that are carried up
    for (genvar k = 0; k < NV_W; k++) begin : g_fed
        if (k < NV) begin : g_use
            localparam int I   = FED_LO + k;
            localparam int J   = T - 1 - I;
            localparam bit INV = tmul_pkg::is_inv(I, J, NA, NB, SGN);
            assign fed_bits[k] = (a[I] & b[J]) ^ INV;
        end else begin : g_none
            assign fed_bits[k] = 1'b0;
        end
    end
endmodule

// File: rtl/tmul_fed.sv
module tmul_fed #(
    parameter int W    = 16,
    parameter int T    = 5,
    parameter int NV_W = 2,
    localparam int CW  = $clog2(NV_W + 1)
) (
    input  logic [NV_W-1:0] fed_bits,
    output logic [W-1:0]    fed_word
);
    logic [CW-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int k = 0; k < NV_W; k++)
            cnt = cnt + CW'(fed_bits[k]);
        fed_word = W'(cnt) << T;
    end
endmodule

// File: rtl/tmul_sum.sv
module tmul_sum #(
    parameter int          NB   = 8,
    parameter int          W    = 16,
    parameter int          RW   = 8,
    parameter logic [W-1:0] CORR = '0
) (
    input  logic [NB-1:0][W-1:0] rows,
    input  logic [W-1:0]         fed_word,
    output logic [RW-1:0]        res
);
    logic [W-1:0] acc;

    always_comb begin
        acc = CORR + fed_word;
        for (int j = 0; j < NB; j++)
            acc = acc + rows[j];
        res = RW'(acc >> (W - RW));
    end
endmodule

// File: rtl/tmul_trunc.sv
module tmul_trunc #(
    parameter int                     NA      = 8,
    parameter int                     NB      = 8,
    parameter int                     RW      = 8,
    parameter int                     KG      = 3,
    parameter tmul_pkg::corr_mode_e   MODE    = tmul_pkg::CORR_HYBRID,
    parameter int                     HYB_PCT = 50,
    parameter bit                     SGN     = 1'b0,
    parameter bit                     REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NA-1:0] a_in,
    input  logic [NB-1:0] b_in,
    output logic [RW-1:0] prod_out
);
    localparam int     W      = NA + NB;
    localparam int     T      = W - RW - KG;
    localparam int     NV     = tmul_pkg::fed_count(MODE, NA, NB, T, HYB_PCT);
    localparam int     NV_W   = (NV > 0) ? NV : 1;
    localparam longint CORR_L = tmul_pkg::corr_word(NA, NB, RW, KG, MODE, HYB_PCT, SGN);
    localparam logic [W-1:0] CORR = CORR_L[W-1:0];

    logic [NB-1:0][W-1:0] rows;
    logic [NV_W-1:0]      fed_bits;
    logic [W-1:0]         fed_word;
    logic [RW-1:0]        res;

    tmul_ppmat #(.NA(NA), .NB(NB), .T(T), .NV(NV), .SGN(SGN)) u_ppmat (
        .a        (a_in),
        .b        (b_in),
        .rows     (rows),
        .fed_bits (fed_bits)
    );

    tmul_fed #(.W(W), .T(T), .NV_W(NV_W)) u_fed (
        .fed_bits (fed_bits),
        .fed_word (fed_word)
    );

    tmul_sum #(.NB(NB), .W(W), .RW(RW), .CORR(CORR)) u_sum (
        .rows     (rows),
        .fed_word (fed_word),
        .res      (res)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) prod_out <= '0;
            else     prod_out <= res;
        end
    end else begin : g_comb
        assign prod_out = res;
    end
endmodule

// File: rtl/tmul_trunc_chk.sv
module tmul_trunc_chk #(
    parameter int NA      = 8,
    parameter int NB      = 8,
    parameter int RW      = 8,
    parameter bit SGN     = 1'b0,
    parameter bit REG_OUT = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic [NA-1:0] a_in,
    input logic [NB-1:0] b_in,
    input logic [RW-1:0] prod_out
);
    localparam longint ULP = longint'(1) << (NA + NB - RW);

    logic [NA-1:0] a_q;
    logic [NB-1:0] b_q;
    logic          seen;
    logic [NA-1:0] ua;
    logic [NB-1:0] ub;
    longint        exact;
    longint        approx;
    longint        err;
    logic          err_ok;
    logic          chk_valid;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
        a_q <= a_in;
        b_q <= b_in;
    end

    always_comb begin
        ua = REG_OUT ? a_q : a_in;
        ub = REG_OUT ? b_q : b_in;
        if (SGN) begin
            exact  = longint'($signed(ua)) * longint'($signed(ub));
            approx = longint'($signed(prod_out)) * ULP;
        end else begin
            exact  = longint'(ua) * longint'(ub);
            approx = longint'(prod_out) * ULP;
        end
        err       = approx - exact;
        err_ok    = (err <= ULP) && (err >= -ULP);
        chk_valid = REG_OUT ? seen : 1'b1;
    end

    // R1 R2 R3 R4 R5: one-ulp bound against the exact product
    a_r1_err_bound: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> err_ok);

    if (REG_OUT) begin : g_reg_chk
        a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (prod_out == '0));
        a_r7_zero_operand: assert property (@(posedge clk) disable iff (rst)
            (a_in == '0 || b_in == '0) |=> (prod_out == '0));
        a_r10_stable: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $stable(a_in) && $stable(b_in)) |=> $stable(prod_out));
    end else begin : g_comb_chk
        a_r7_zero_operand: assert property (@(posedge clk) disable iff (rst)
            (a_in == '0 || b_in == '0) |-> (prod_out == '0));
        a_r9_r10_follow: assert property (@(posedge clk) disable iff (rst)
            ($stable(a_in) && $stable(b_in)) |-> $stable(prod_out));
    end
endmodule

bind tmul_trunc tmul_trunc_chk #(
    .NA(NA), .NB(NB), .RW(RW), .SGN(SGN), .REG_OUT(REG_OUT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .a_in     (a_in),
    .b_in     (b_in),
    .prod_out (prod_out)
);

// File: tb/test_tmul_trunc.sv
module test_tmul_trunc;
    localparam int     NA    = 6;
    localparam int     NB    = 6;
    localparam int     RW    = 6;
    localparam int     KG    = 3;
    localparam longint ULP   = longint'(1) << (NA + NB - RW);
    localparam longint NPAIR = longint'(1) << (NA + NB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NA-1:0] a_in = '0;
    logic [NB-1:0] b_in = '0;
    logic [RW-1:0] p_c, p_v, p_h, p_s;

    int     n_chk  = 0;
    int     n_fail = 0;
    bit     done   = 1'b0;
    longint sum_c = 0, sum_v = 0, sum_h = 0, sum_s = 0;

    always #5 clk = ~clk;

    tmul_trunc #(.NA(NA), .NB(NB), .RW(RW), .KG(KG), .MODE(tmul_pkg::CORR_CONST),
                 .HYB_PCT(50), .SGN(1'b0), .REG_OUT(1'b1)) i_tmul_trunc (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .prod_out(p_c));
    tmul_trunc #(.NA(NA), .NB(NB), .RW(RW), .KG(KG), .MODE(tmul_pkg::CORR_VAR),
                 .HYB_PCT(50), .SGN(1'b0), .REG_OUT(1'b1)) i_tmul_trunc_var (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .prod_out(p_v));
    tmul_trunc #(.NA(NA), .NB(NB), .RW(RW), .KG(KG), .MODE(tmul_pkg::CORR_HYBRID),
                 .HYB_PCT(50), .SGN(1'b0), .REG_OUT(1'b1)) i_tmul_trunc_hyb (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .prod_out(p_h));
    tmul_trunc #(.NA(NA), .NB(NB), .RW(RW), .KG(KG), .MODE(tmul_pkg::CORR_HYBRID),
                 .HYB_PCT(50), .SGN(1'b1), .REG_OUT(1'b0)) i_tmul_trunc_sgn (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .prod_out(p_s));

    task automatic check(input bit ok, input string req, input longint act,
                         input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint err_u(input logic [RW-1:0] r, input logic [NA-1:0] a,
                                     input logic [NB-1:0] b);
        return longint'(r) * ULP - longint'(a) * longint'(b);
    endfunction

    function automatic longint err_s(input logic [RW-1:0] r, input logic [NA-1:0] a,
                                     input logic [NB-1:0] b);
        return longint'($signed(r)) * ULP - longint'($signed(a)) * longint'($signed(b));
    endfunction

    function automatic longint mag(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check_bound(input string req, input longint e);
        check(mag(e) <= ULP, req, e, ULP);
    endtask

    // compare all four copies against the operands applied one cycle earlier
    task automatic compare(input logic [NA-1:0] pa, input logic [NB-1:0] pb,
                           input bit acc);
        longint ec, ev, eh, es;
        ec = err_u(p_c, pa, pb);
        ev = err_u(p_v, pa, pb);
        eh = err_u(p_h, pa, pb);
        es = err_s(p_s, pa, pb);
        check_bound("R2 constant-mode error bound", ec);
        check_bound("R3 variable-mode error bound", ev);
        check_bound("R4 hybrid-mode error bound", eh);
        check_bound("R5 signed error bound", es);
        if (acc) begin
            sum_c += ec; sum_v += ev; sum_h += eh; sum_s += es;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        logic [NA-1:0] pa;
        logic [NB-1:0] pb;
        logic [RW-1:0] hold_c, hold_s;

        // R8: reset holds registered outputs at zero even with busy operands
        a_in = '1; b_in = '1;
        @(posedge clk);
        @(negedge clk);
        check(p_c == '0, "R8 reset clears registered output", longint'(p_c), 0);
        check(p_v == '0, "R8 reset clears registered output", longint'(p_v), 0);
        check(p_h == '0, "R8 reset clears registered output", longint'(p_h), 0);
        rst = 1'b0;
        @(negedge clk);
        // R1: unsigned full-scale product lands in the top result bits
        check(p_c == 6'd62 || p_c == 6'd63, "R1 full-scale unsigned result", longint'(p_c), 62);
        check(p_v == 6'd62 || p_v == 6'd63, "R1 full-scale unsigned result", longint'(p_v), 62);
        check(p_h == 6'd62 || p_h == 6'd63, "R1 full-scale unsigned result", longint'(p_h), 62);

        // exhaustive sweep, R2..R5 on every pair
        pa = '0; pb = '0;
        for (int ai = 0; ai < (1 << NA); ai++) begin
            for (int bi = 0; bi < (1 << NB); bi++) begin
                @(negedge clk);
                if (ai != 0 || bi != 0) compare(pa, pb, 1'b1);
                a_in = NA'(ai); b_in = NB'(bi);
                pa = a_in; pb = b_in;
            end
        end
        @(negedge clk);
        compare(pa, pb, 1'b1);
        // the first pair (0,0): all errors are zero by R7 checks below, add nothing

        // R6: mean error within a quarter ulp
        check(mag(sum_c) * 4 <= ULP * NPAIR, "R6 constant-mode mean error", sum_c / NPAIR, 0);
        check(mag(sum_v) * 4 <= ULP * NPAIR, "R6 variable-mode mean error", sum_v / NPAIR, 0);
        check(mag(sum_h) * 4 <= ULP * NPAIR, "R6 hybrid-mode mean error", sum_h / NPAIR, 0);
        check(mag(sum_s) * 4 <= ULP * NPAIR, "R6 signed mean error", sum_s / NPAIR, 0);

        // R7: zero operand gives zero
        a_in = '0; b_in = 6'd37;
        @(negedge clk);
        check(p_c == '0 && p_v == '0 && p_h == '0, "R7 zero multiplicand",
              longint'(p_c) + longint'(p_v) + longint'(p_h), 0);
        check(p_s == '0, "R7 zero multiplicand signed", longint'(p_s), 0);
        a_in = 6'd45; b_in = '0;
        @(negedge clk);
        check(p_c == '0 && p_v == '0 && p_h == '0, "R7 zero multiplier",
              longint'(p_c) + longint'(p_v) + longint'(p_h), 0);
        check(p_s == '0, "R7 zero multiplier signed", longint'(p_s), 0);

        // R8 latency and R9 combinational path: prior operands give zero
        a_in = '0; b_in = '0;
        @(negedge clk);
        a_in = 6'd31; b_in = 6'd31;
        #1;
        check(p_c == '0, "R8 registered output waits one cycle", longint'(p_c), 0);
        check_bound("R9 combinational output follows inputs at once",
                    err_s(p_s, 6'd31, 6'd31));
        @(negedge clk);
        check_bound("R8 registered output after one cycle", err_u(p_c, 6'd31, 6'd31));

        // R10: steady operands keep steady outputs
        a_in = 6'd45; b_in = 6'd27;
        @(negedge clk);
        hold_c = p_c; hold_s = p_s;
        @(negedge clk);
        @(negedge clk);
        check(p_c == hold_c, "R10 output stable with steady operands", longint'(p_c), longint'(hold_c));
        check(p_s == hold_s, "R10 output stable with steady operands", longint'(p_s), longint'(hold_s));

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule